// File: doc/BRIEF.md
# Data-Processing ALU with Status Flags

This block is the combinational arithmetic and logic stage of a 32-bit integer core. Each cycle it takes a 4-bit operation code, the first operand register value, the second operand as already produced by the barrel shifter, the shifter's carry-out and the current condition flags. It returns the result, whether the destination register is written, the next value of the negative, zero, carry and overflow flags, and two side indications: a request to restore the whole current status word from the saved status word, and a program-counter write that the fetch logic must treat as a branch and flush on.

The sixteen operations cover bitwise logic, moves, four kinds of subtraction, two of addition, and four compare/test forms that update flags without writing a register. Operand fetch, shifting and the status registers themselves live outside the block; the caller latches `flagsOut` and acts on `restoreStatus` and `pcWrite`.

Top module: `dp_alu`

## Requirements
- R1: Operation codes are 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN; the logical ones give Rn&op2, Rn^op2, Rn|op2, op2, Rn&~op2 and ~op2, and TST/TEQ compute Rn&op2 and Rn^op2.
- R2: SUB gives Rn-op2, RSB op2-Rn, ADD Rn+op2, ADC Rn+op2+C, SBC Rn-op2-(1-C), RSC op2-Rn-(1-C), CMP computes Rn-op2 and CMN Rn+op2, all modulo 2^32.
- R3: Codes 8 to 11 never assert the register write and always update flags whatever the S input.
- R4: When flags are computed, N equals result bit 31 and Z is set exactly when the result is zero.
- R5: For the arithmetic codes C is the carry out of bit 31 for additions and the inverse of the borrow for subtractions.
- R6: For the arithmetic codes V is set exactly when the true signed result does not fit in 32 bits.
- R7: For the logical codes C takes the shifter carry-out and V keeps its incoming value.
- R8: With S clear and a non-compare code, the flag outputs equal the flag inputs.
- R9: With flags being updated, Rd being the PC and a saved status present, restoreStatus is 1 and the flag outputs equal the inputs; otherwise restoreStatus is 0.
- R10: pcWrite is 1 exactly when the register is written and Rd is the PC.
- R11: Codes other than 8 to 11 always assert the register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | Operation code |
| sBit | input | 1 | Update flags request |
| rnVal | input | 32 | First operand |
| opVal | input | 32 | Shifted second operand |
| shCarry | input | 1 | Shifter carry-out |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| rdIsPc | input | 1 | Destination is the program counter |
| hasSaved | input | 1 | Current mode owns a saved status word |
| result | output | 32 | Operation result |
| regWe | output | 1 | Destination register write enable |
| flagsOut | output | 4 | Next flags {N,Z,C,V} |
| restoreStatus | output | 1 | Copy saved status into current status |
| pcWrite | output | 1 | Program counter written; flush fetch |

## Verification
The checks evaluate combinationally and assume every input is a settled, known value whenever the outputs are sampled; they also assume the flag inputs are the ones the caller will replace, so a flag-hold check compares against them directly. The stimulus changes all inputs together in one step and waits before sampling, sweeping every code, S value, carry, shifter carry and the restore/PC combinations over operands chosen at the sign and carry boundaries (0, 1, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and neighbours).

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} carrySel_e;

  typedef enum logic [2:0] {LG_AND, LG_XOR, LG_OR, LG_PASS, LG_CLEAR, LG_NOT} logicSel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic      useAdder;
    logic      invRn;
    logic      invOp;
    carrySel_e carrySel;
    logicSel_e logicSel;
    logic      writeRd;
    logic      updFlags;
    logic      restore;
    logic      flush;
  } aluStrobe_t;

endpackage

// File: rtl/dp_alu_ctrl.sv
module dp_alu_ctrl
  import dp_alu_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic       sBit,
  input  logic       rdIsPc,
  input  logic       hasSaved,
  output aluStrobe_t strobe
);

  logic isCompare;
  logic wantFlags;

  assign isCompare = (opcode[3:2] == 2'b10);
  assign wantFlags = sBit | isCompare;

  always_comb begin
    strobe          = '0;
    strobe.carrySel = CIN_ZERO;
    strobe.logicSel = LG_PASS;
    unique case (aluOp_e'(opcode))
      OP_AND, OP_TST: strobe.logicSel = LG_AND;
      OP_EOR, OP_TEQ: strobe.logicSel = LG_XOR;
      OP_ORR:         strobe.logicSel = LG_OR;
      OP_MOV:         strobe.logicSel = LG_PASS;
      OP_BIC:         strobe.logicSel = LG_CLEAR;
      OP_MVN:         strobe.logicSel = LG_NOT;
      OP_SUB, OP_CMP: begin
        strobe.useAdder = 1'b1;
        strobe.invOp    = 1'b1;
        strobe.carrySel = CIN_ONE;
      end
      OP_RSB: begin
        strobe.useAdder = 1'b1;
        strobe.invRn    = 1'b1;
        strobe.carrySel = CIN_ONE;
      end
      OP_ADD, OP_CMN: strobe.useAdder = 1'b1;
      OP_ADC: begin
        strobe.useAdder = 1'b1;
        strobe.carrySel = CIN_FLAG;
      end
      OP_SBC: begin
        strobe.useAdder = 1'b1;
        strobe.invOp    = 1'b1;
        strobe.carrySel = CIN_FLAG;
      end
      OP_RSC: begin
        strobe.useAdder = 1'b1;
        strobe.invRn    = 1'b1;
        strobe.carrySel = CIN_FLAG;
      end
      default: strobe.logicSel = LG_PASS;
    endcase
    strobe.writeRd  = ~isCompare;
    strobe.updFlags = wantFlags;
    strobe.restore  = wantFlags & rdIsPc & hasSaved;
    strobe.flush    = ~isCompare & rdIsPc;
  end

endmodule

// File: rtl/dp_alu_datapath.sv
module dp_alu_datapath
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] rnVal,
  input  logic [DATA_W-1:0] opVal,
  input  logic              shCarry,
  input  flags_t            flagsIn,
  output logic [DATA_W-1:0] result,
  output flags_t            flagsOut
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addA;
  logic [DATA_W-1:0] addB;
  logic              carryIn;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] logicRes;
  logic              addOvf;
  flags_t            computed;

  assign addA = strobe.invRn ? ~rnVal : rnVal;
  assign addB = strobe.invOp ? ~opVal : opVal;

  always_comb begin
    unique case (strobe.carrySel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = flagsIn.c;
      default:  carryIn = 1'b0;
    endcase
  end

  assign sum    = {1'b0, addA} + {1'b0, addB} + {{DATA_W{1'b0}}, carryIn};
  assign addOvf = (addA[MSB] == addB[MSB]) && (sum[MSB] != addA[MSB]);

  always_comb begin
    unique case (strobe.logicSel)
      LG_AND:   logicRes = rnVal & opVal;
      LG_XOR:   logicRes = rnVal ^ opVal;
      LG_OR:    logicRes = rnVal | opVal;
      LG_CLEAR: logicRes = rnVal & ~opVal;
      LG_NOT:   logicRes = ~opVal;
      default:  logicRes = opVal;
    endcase
  end

  assign result = strobe.useAdder ? sum[DATA_W-1:0] : logicRes;

  always_comb begin
    computed.n = result[MSB];
    computed.z = (result == '0);
    computed.c = strobe.useAdder ? sum[DATA_W] : shCarry;
    computed.v = strobe.useAdder ? addOvf : flagsIn.v;
    if (strobe.updFlags && !strobe.restore) flagsOut = computed;
    else                                    flagsOut = flagsIn;
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        opcode,
  input  logic              sBit,
  input  logic [DATA_W-1:0] rnVal,
  input  logic [DATA_W-1:0] opVal,
  input  logic              shCarry,
  input  logic [3:0]        flagsIn,
  input  logic              rdIsPc,
  input  logic              hasSaved,
  output logic [DATA_W-1:0] result,
  output logic              regWe,
  output logic [3:0]        flagsOut,
  output logic              restoreStatus,
  output logic              pcWrite
);

  aluStrobe_t strobe;
  flags_t     nextFlags;

  dp_alu_ctrl ctrl_i (
    .opcode   (opcode),
    .sBit     (sBit),
    .rdIsPc   (rdIsPc),
    .hasSaved (hasSaved),
    .strobe   (strobe)
  );

  dp_alu_datapath #(.DATA_W(DATA_W)) dpath_i (
    .strobe   (strobe),
    .rnVal    (rnVal),
    .opVal    (opVal),
    .shCarry  (shCarry),
    .flagsIn  (flags_t'(flagsIn)),
    .result   (result),
    .flagsOut (nextFlags)
  );

  assign flagsOut      = nextFlags;
  assign regWe         = strobe.writeRd;
  assign restoreStatus = strobe.restore;
  assign pcWrite       = strobe.flush;

endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
  parameter int DATA_W = 32
) (
  input logic [3:0]        opcode,
  input logic              sBit,
  input logic [DATA_W-1:0] result,
  input logic              shCarry,
  input logic [3:0]        flagsIn,
  input logic              rdIsPc,
  input logic              regWe,
  input logic [3:0]        flagsOut,
  input logic              restoreStatus,
  input logic              pcWrite
);

  logic cmpOp;
  logic logicOp;
  logic liveFlags;

  assign cmpOp     = opcode[3] & ~opcode[2];
  assign logicOp   = (opcode == 4'd0) || (opcode == 4'd1) || (opcode == 4'd8) ||
                     (opcode == 4'd9) || (opcode >= 4'd12);
  assign liveFlags = (sBit || cmpOp) && !restoreStatus;

  always_comb begin
    assert_cmp_no_write_R3: assert (!(cmpOp && regWe));
    assert_write_enable_R11: assert (cmpOp || regWe);
    if (!sBit && !cmpOp) begin
      assert_flags_hold_R8: assert (flagsOut == flagsIn);
    end
    if (liveFlags) begin
      assert_nz_track_R4: assert (flagsOut[3] == result[DATA_W-1] &&
                                  flagsOut[2] == (result == '0));
    end
    if (liveFlags && logicOp) begin
      assert_logic_cv_R7: assert (flagsOut[1] == shCarry && flagsOut[0] == flagsIn[0]);
    end
    if (restoreStatus) begin
      assert_restore_hold_R9: assert (flagsOut == flagsIn && rdIsPc);
    end
    if (pcWrite) begin
      assert_flush_write_R10: assert (regWe && rdIsPc);
    end
  end

endmodule

bind dp_alu dp_alu_checker #(.DATA_W(DATA_W)) chk_i (
  .opcode        (opcode),
  .sBit          (sBit),
  .result        (result),
  .shCarry       (shCarry),
  .flagsIn       (flagsIn),
  .rdIsPc        (rdIsPc),
  .regWe         (regWe),
  .flagsOut      (flagsOut),
  .restoreStatus (restoreStatus),
  .pcWrite       (pcWrite)
);

// File: tb/dp_alu_tb_top.sv
module dp_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = '0;
  logic        sBit = 1'b0;
  logic [31:0] rnVal = '0;
  logic [31:0] opVal = '0;
  logic        shCarry = 1'b0;
  logic [3:0]  flagsIn = '0;
  logic        rdIsPc = 1'b0;
  logic        hasSaved = 1'b0;
  logic [31:0] result;
  logic        regWe;
  logic [3:0]  flagsOut;
  logic        restoreStatus;
  logic        pcWrite;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  dp_alu dut_i (
    .opcode(opcode), .sBit(sBit), .rnVal(rnVal), .opVal(opVal),
    .shCarry(shCarry), .flagsIn(flagsIn), .rdIsPc(rdIsPc), .hasSaved(hasSaved),
    .result(result), .regWe(regWe), .flagsOut(flagsOut),
    .restoreStatus(restoreStatus), .pcWrite(pcWrite)
  );

  logic [31:0] vals [8];
  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
    vals[2] = 32'h7FFF_FFFF; vals[3] = 32'h8000_0000;
    vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;
    vals[6] = 32'hFFFF_FFFE; vals[7] = 32'h8000_0001;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d s=%0b rn=%h op2=%h actual=%h expected=%h",
               tag, opcode, sBit, rnVal, opVal, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  task automatic model(output logic [31:0] eRes, output logic eWe, output logic [3:0] eFl,
                       output logic eRest, output logic ePc, output string ftag);
    longint unsigned ua, ub, cy, u;
    longint sa, sb, s;
    logic arith, cmp, upd, c, v;
    ua = longint'(rnVal); ub = longint'(opVal);
    sa = longint'($signed(rnVal)); sb = longint'($signed(opVal));
    cy = longint'(flagsIn[1]);
    arith = 1'b1; c = 1'b0; v = flagsIn[0]; s = 0;
    case (opcode)
      4'd0, 4'd8: begin eRes = rnVal & opVal; arith = 0; end
      4'd1, 4'd9: begin eRes = rnVal ^ opVal; arith = 0; end
      4'd12: begin eRes = rnVal | opVal; arith = 0; end
      4'd13: begin eRes = opVal; arith = 0; end
      4'd14: begin eRes = rnVal & ~opVal; arith = 0; end
      4'd15: begin eRes = ~opVal; arith = 0; end
      4'd2, 4'd10: begin u = ua - ub; c = (ua >= ub); s = sa - sb; end
      4'd3: begin u = ub - ua; c = (ub >= ua); s = sb - sa; end
      4'd4, 4'd11: begin u = ua + ub; c = u[32]; s = sa + sb; end
      4'd5: begin u = ua + ub + cy; c = u[32]; s = sa + sb + longint'(cy); end
      4'd6: begin u = ua - ub - (1 - cy); c = (ua >= ub + (1 - cy));
                  s = sa - sb - longint'(1 - cy); end
      default: begin u = ub - ua - (1 - cy); c = (ub >= ua + (1 - cy));
                  s = sb - sa - longint'(1 - cy); end
    endcase
    if (arith) begin
      eRes = u[31:0];
      v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      ftag = "R5_R6";
    end else begin
      c = shCarry;
      ftag = "R7";
    end
    cmp   = (opcode >= 4'd8) && (opcode <= 4'd11);
    upd   = sBit || cmp;
    eWe   = !cmp;
    eRest = upd && rdIsPc && hasSaved;
    ePc   = eWe && rdIsPc;
    if (!upd) begin eFl = flagsIn; ftag = "R8"; end
    else if (eRest) begin eFl = flagsIn; ftag = "R9"; end
    else eFl = {eRes[31], eRes == 32'd0, c, v};
  endtask

  task automatic apply_and_check();
    logic [31:0] eRes; logic eWe, eRest, ePc; logic [3:0] eFl; string ft;
    #1;
    model(eRes, eWe, eFl, eRest, ePc, ft);
    check((opcode < 4'd2 || opcode >= 4'd12 || opcode == 4'd8 || opcode == 4'd9) ? "R1" : "R2",
          result, eRes);
    check((opcode >= 4'd8 && opcode <= 4'd11) ? "R3" : "R11", {31'd0, regWe}, {31'd0, eWe});
    check({ft, "_R4"}, {28'd0, flagsOut}, {28'd0, eFl});
    check("R9", {31'd0, restoreStatus}, {31'd0, eRest});
    check("R10", {31'd0, pcWrite}, {31'd0, ePc});
    #1;
  endtask

  always @(posedge clk) begin
    if (!rst) cycles <= cycles + 1;
  end

  initial begin
    wait (!rst && cycles >= 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle/reset-style state: all-zero inputs is AND of zeros with flags untouched.
    #1;
    check("R11", {31'd0, regWe}, 32'd1);
    check("R1", result, 32'd0);
    check("R8", {28'd0, flagsOut}, 32'd0);
    check("R10", {31'd0, pcWrite}, 32'd0);

    // Directed boundary: 0x7FFFFFFF + 1 overflows, no carry.
    opcode = 4'd4; sBit = 1; rnVal = 32'h7FFF_FFFF; opVal = 32'd1; flagsIn = 4'b0000;
    #1;
    check("R6", {28'd0, flagsOut}, {28'd0, 4'b1001});
    // 0 - 1 with and without carry-in via SBC
    opcode = 4'd6; rnVal = 0; opVal = 1; flagsIn = 4'b0010;
    #1;
    check("R5", {28'd0, flagsOut}, {28'd0, 4'b1000});
    check("R2", result, 32'hFFFF_FFFF);
    flagsIn = 4'b0000;
    #1;
    check("R2", result, 32'hFFFF_FFFE);

    // Near-exhaustive sweep.
    for (int op = 0; op < 16; op++)
      for (int sb = 0; sb < 2; sb++)
        for (int cf = 0; cf < 2; cf++)
          for (int sc = 0; sc < 2; sc++)
            for (int pc = 0; pc < 4; pc++)
              for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++) begin
                  opcode   = 4'(op);
                  sBit     = sb[0];
                  shCarry  = sc[0];
                  flagsIn  = {sc[0], cf[0] ^ sc[0], cf[0], ~cf[0]};
                  rdIsPc   = pc[0];
                  hasSaved = pc[1];
                  rnVal    = vals[a];
                  opVal    = vals[b];
                  apply_and_check();
                end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule